// File: doc/BRIEF.md
# Binary Tree Longest-Prefix Lookup

This block resolves a lookup key of variable length to a forwarding result by walking a binary decision tree. The tree is held in an on-chip node table. At each internal node the walker reads one chosen key bit and follows either the zero child or the one child. Any node can carry a candidate result. A candidate is confirmed by comparing the key against the node's stored pattern over the candidate's prefix length. The longest confirmed candidate seen along the path is returned as a next-hop id plus a destination mask length.

Keys enter through a valid/ready handshake, and only one walk runs at a time. The walk visits one node per clock, starting at node 0. It ends on one of four conditions:
- it reaches a leaf;
- a node tests a bit beyond the key's length;
- a node tests a bit beyond the key width;
- a fixed step budget is used up.

When the walk ends, the result is presented with a one-cycle done pulse and stays on the outputs until the next pulse. The node table is filled through a plain write port. Building the tree is left to software.

Top module: `lpm_lookup`

## Requirements
- R1: After reset `in_ready` is 1, and `res_done`, `res_miss`, `res_nh` and `res_mlen` are all 0.
- R2: A key and its length are taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle that carries the done pulse.
- R3: `res_done` is high for exactly one cycle per accepted key.
- R4: At a non-leaf node the walk moves to the one-child if key bit `bit_idx` is 1 and to the zero-child if it is 0. Key bit i is `in_key[i]`, so bit 0 is the first key bit.
- R5: A node's candidate (result-valid bit set) matches only when both of these hold: its mask length is no more than the key length, and key bits 0 to mask length minus 1 equal the same pattern bits. A leaf always ends the walk, whether or not it matches.
- R6: A matching candidate replaces the best so far only if no best exists yet or its mask length is at least the best's. The returned mask length never exceeds the key length.
- R7: A non-leaf node whose `bit_idx` is at least the key length (0 to KEY_W) or at least KEY_W ends the walk with the best result so far.
- R8: If no candidate matched, `res_miss` is 1 and `res_nh` and `res_mlen` are 0. Otherwise `res_miss` is 0 and the best's next-hop id and mask length are returned.
- R9: The done pulse arrives exactly V cycles after the accepting edge, where V is the number of nodes visited. A walk visits at most 2^NODE_AW nodes and stops at that count.
- R10: While a walk runs, `in_valid`, `in_key` and `in_len` have no effect. Result outputs change only on the edge that raises `res_done`.
- R11: When `wr_en` is 1, a rising edge stores `wr_data` at `wr_addr`, and later walks use it. The word is laid out from the LSB up as follows: pattern (KEY_W bits), mask length (LEN_W), next-hop id (NH_W), result-valid bit, one-child pointer (NODE_AW), zero-child pointer (NODE_AW), bit index (LEN_W), and the leaf flag in the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key offered |
| in_ready | output | 1 | Block idle, key can be taken |
| in_key | input | KEY_W | Key bits, bit 0 first |
| in_len | input | LEN_W | Key length in bits, 0 to KEY_W |
| wr_en | input | 1 | Node table write strobe |
| wr_addr | input | NODE_AW | Node index to write |
| wr_data | input | NODE_W | Packed node word |
| res_done | output | 1 | One-cycle result strobe |
| res_miss | output | 1 | No candidate matched |
| res_nh | output | NH_W | Next-hop id of best match |
| res_mlen | output | LEN_W | Destination mask length of best match |

## Verification
The bench builds the block with KEY_W=32, NODE_AW=5 and NH_W=12. This gives a 32-entry table that is small enough for random trees to form cycles, so the 32-visit step budget is actually reached. Every key length from 0 to the full width can be drawn. Bit indices past the 32-bit width are reachable because the 6-bit index field goes up to 63. Random trees draw node patterns from a shared base key with sparse bit flips, so both partial and full prefix matches occur often. Directed trees pin down branching direction, the longest-wins rule, fallback after a failed leaf, the empty-table miss and input changes during a walk.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_st_e;

    function automatic int len_bits(input int key_w);
        return $clog2(key_w + 1);
    endfunction

    function automatic int node_bits(input int key_w, input int aw, input int nh_w);
        return 1 + 2 * len_bits(key_w) + 2 * aw + 1 + nh_w + key_w;
    endfunction

endpackage

// File: rtl/lpm_node_mem.sv
module lpm_node_mem #(
    parameter int AW = 5,
    parameter int W  = 64
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/lpm_prefix_cmp.sv
module lpm_prefix_cmp #(
    parameter int KEY_W = 32,
    localparam int LW   = lpm_pkg::len_bits(KEY_W)
) (
    input  logic [KEY_W-1:0] key,
    input  logic [LW-1:0]    klen,
    input  logic [KEY_W-1:0] pat,
    input  logic [LW-1:0]    mlen,
    output logic             hit
);
    logic [KEY_W-1:0] diff;

    for (genvar g = 0; g < KEY_W; g++) begin : g_bit
        assign diff[g] = (key[g] ^ pat[g]) & (LW'(g) < mlen);
    end

    assign hit = (mlen <= klen) && ~|diff;
endmodule

// File: rtl/lpm_walk_ctrl.sv
module lpm_walk_ctrl #(
    parameter int KEY_W = 32,
    parameter int AW    = 5,
    parameter int NH_W  = 12,
    localparam int LW   = lpm_pkg::len_bits(KEY_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    input  logic [LW-1:0]    in_len,
    input  logic             nd_leaf,
    input  logic [LW-1:0]    nd_bit,
    input  logic [AW-1:0]    nd_c0,
    input  logic [AW-1:0]    nd_c1,
    input  logic             nd_rvld,
    input  logic [NH_W-1:0]  nd_nh,
    input  logic [LW-1:0]    nd_mlen,
    input  logic             nd_hit,
    output logic [AW-1:0]    ptr,
    output logic [KEY_W-1:0] key_q,
    output logic [LW-1:0]    klen_q,
    output logic             res_done,
    output logic             res_miss,
    output logic [NH_W-1:0]  res_nh,
    output logic [LW-1:0]    res_mlen
);
    import lpm_pkg::*;

    typedef struct packed {
        logic            vld;
        logic [NH_W-1:0] nh;
        logic [LW-1:0]   mlen;
    } best_t;

    walk_st_e      st;
    logic [AW-1:0] steps;
    best_t         best, best_nx;
    logic          take, stop, kb;

    assign in_ready = (st == ST_IDLE);

    always_comb begin
        kb = 1'b0;
        for (int i = 0; i < KEY_W; i++) begin
            if (nd_bit == LW'(i)) kb = key_q[i];
        end
    end

    assign take = nd_rvld && nd_hit && (!best.vld || nd_mlen >= best.mlen);

    always_comb begin
        best_nx = best;
        if (take) begin
            best_nx.vld  = 1'b1;
            best_nx.nh   = nd_nh;
            best_nx.mlen = nd_mlen;
        end
    end

    assign stop = nd_leaf || (nd_bit >= klen_q) || (nd_bit >= LW'(KEY_W)) || (steps == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ptr      <= '0;
            steps    <= '0;
            key_q    <= '0;
            klen_q   <= '0;
            best     <= '0;
            res_done <= 1'b0;
            res_miss <= 1'b0;
            res_nh   <= '0;
            res_mlen <= '0;
        end else begin
            res_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        key_q  <= in_key;
                        klen_q <= in_len;
                        ptr    <= '0;
                        steps  <= '0;
                        best   <= '0;
                        st     <= ST_WALK;
                    end
                end
                default: begin
                    if (stop) begin
                        res_done <= 1'b1;
                        res_miss <= !best_nx.vld;
                        res_nh   <= best_nx.vld ? best_nx.nh : '0;
                        res_mlen <= best_nx.vld ? best_nx.mlen : '0;
                        st       <= ST_IDLE;
                    end else begin
                        best  <= best_nx;
                        ptr   <= kb ? nd_c1 : nd_c0;
                        steps <= steps + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup #(
    parameter int KEY_W   = 248,
    parameter int NODE_AW = 6,
    parameter int NH_W    = 16,
    localparam int LEN_W  = lpm_pkg::len_bits(KEY_W),
    localparam int NODE_W = lpm_pkg::node_bits(KEY_W, NODE_AW, NH_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [KEY_W-1:0]   in_key,
    input  logic [LEN_W-1:0]   in_len,
    input  logic               wr_en,
    input  logic [NODE_AW-1:0] wr_addr,
    input  logic [NODE_W-1:0]  wr_data,
    output logic               res_done,
    output logic               res_miss,
    output logic [NH_W-1:0]    res_nh,
    output logic [LEN_W-1:0]   res_mlen
);
    localparam int ML_LO = KEY_W;
    localparam int NH_LO = ML_LO + LEN_W;
    localparam int RV_B  = NH_LO + NH_W;
    localparam int C1_LO = RV_B + 1;
    localparam int C0_LO = C1_LO + NODE_AW;
    localparam int BI_LO = C0_LO + NODE_AW;
    localparam int LF_B  = BI_LO + LEN_W;

    logic [NODE_AW-1:0] ptr;
    logic [NODE_W-1:0]  node;
    logic [KEY_W-1:0]   key_q;
    logic [LEN_W-1:0]   klen_q;
    logic               hit;

    lpm_node_mem #(.AW(NODE_AW), .W(NODE_W)) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(ptr),
        .rd_data(node)
    );

    lpm_prefix_cmp #(.KEY_W(KEY_W)) u_cmp (
        .key (key_q),
        .klen(klen_q),
        .pat (node[KEY_W-1:0]),
        .mlen(node[ML_LO +: LEN_W]),
        .hit (hit)
    );

    lpm_walk_ctrl #(.KEY_W(KEY_W), .AW(NODE_AW), .NH_W(NH_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .in_key  (in_key),
        .in_len  (in_len),
        .nd_leaf (node[LF_B]),
        .nd_bit  (node[BI_LO +: LEN_W]),
        .nd_c0   (node[C0_LO +: NODE_AW]),
        .nd_c1   (node[C1_LO +: NODE_AW]),
        .nd_rvld (node[RV_B]),
        .nd_nh   (node[NH_LO +: NH_W]),
        .nd_mlen (node[ML_LO +: LEN_W]),
        .nd_hit  (hit),
        .ptr     (ptr),
        .key_q   (key_q),
        .klen_q  (klen_q),
        .res_done(res_done),
        .res_miss(res_miss),
        .res_nh  (res_nh),
        .res_mlen(res_mlen)
    );
endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
    parameter int KEY_W   = 248,
    parameter int NODE_AW = 6,
    parameter int NH_W    = 16,
    localparam int LEN_W  = lpm_pkg::len_bits(KEY_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LEN_W-1:0] in_len,
    input logic             res_done,
    input logic             res_miss,
    input logic [NH_W-1:0]  res_nh,
    input logic [LEN_W-1:0] res_mlen
);
    localparam int MAX_VISIT = 1 << NODE_AW;

    logic             past_ok;
    logic [LEN_W-1:0] klen_cap;
    int unsigned      busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok  <= 1'b0;
            klen_cap <= '0;
            busy_cnt <= 0;
        end else begin
            past_ok <= 1'b1;
            if (in_valid && in_ready) begin
                klen_cap <= in_len;
                busy_cnt <= 0;
            end else if (!in_ready) begin
                busy_cnt <= busy_cnt + 1;
            end
        end
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        res_done |=> !res_done);

    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_miss) |-> (res_nh == '0 && res_mlen == '0));

    a_r6_mlen_within_key: assert property (@(posedge clk) disable iff (rst)
        (res_done && !res_miss) |-> (res_mlen <= klen_cap));

    a_r9_visit_bound: assert property (@(posedge clk) disable iff (rst)
        res_done |-> (busy_cnt >= 1 && busy_cnt <= MAX_VISIT));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !res_done) |-> ($stable(res_nh) && $stable(res_mlen) && $stable(res_miss)));
endmodule

bind lpm_lookup lpm_lookup_chk #(.KEY_W(KEY_W), .NODE_AW(NODE_AW), .NH_W(NH_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_len  (in_len),
    .res_done(res_done),
    .res_miss(res_miss),
    .res_nh  (res_nh),
    .res_mlen(res_mlen)
);

// File: tb/sim_lpm_lookup.sv
`timescale 1ns/1ps
module sim_lpm_lookup;
    localparam int KW    = 32;
    localparam int AW    = 5;
    localparam int NW    = 12;
    localparam int LW    = $clog2(KW + 1);
    localparam int WW    = 1 + 2 * LW + 2 * AW + 1 + NW + KW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [KW-1:0] in_key = '0;
    logic [LW-1:0] in_len = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic          res_done, res_miss;
    logic [NW-1:0] res_nh;
    logic [LW-1:0] res_mlen;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lpm_lookup #(.KEY_W(KW), .NODE_AW(AW), .NH_W(NW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .in_len(in_len), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .res_done(res_done), .res_miss(res_miss),
        .res_nh(res_nh), .res_mlen(res_mlen)
    );

    // bench copy of the table contents
    logic          t_leaf [DEPTH];
    logic [LW-1:0] t_bit  [DEPTH];
    logic [AW-1:0] t_c0   [DEPTH];
    logic [AW-1:0] t_c1   [DEPTH];
    logic          t_rv   [DEPTH];
    logic [NW-1:0] t_nh   [DEPTH];
    logic [LW-1:0] t_ml   [DEPTH];
    logic [KW-1:0] t_pat  [DEPTH];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wnode(input int a, input bit leaf, input int bi, input int c0, input int c1,
                         input bit rv, input int nh, input int ml, input logic [KW-1:0] pat);
        t_leaf[a] = leaf; t_bit[a] = LW'(bi); t_c0[a] = AW'(c0); t_c1[a] = AW'(c1);
        t_rv[a] = rv; t_nh[a] = NW'(nh); t_ml[a] = LW'(ml); t_pat[a] = pat;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = {leaf, LW'(bi), AW'(c0), AW'(c1), rv, NW'(nh), LW'(ml), pat};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_table();
        for (int a = 0; a < DEPTH; a++) wnode(a, 1'b0, 0, 0, 0, 1'b0, 0, 0, '0);
    endtask

    function automatic bit pmatch(input logic [KW-1:0] k, input int len, input logic [KW-1:0] p, input int ml);
        if (ml > len) return 1'b0;
        for (int i = 0; i < ml && i < KW; i++) if (k[i] != p[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void ref_walk(input logic [KW-1:0] k, input int len,
                                     output int enh, output int eml, output bit emiss, output int vis);
        bit bv = 0; int bnh = 0; int bml = 0; int p = 0;
        vis = 0;
        for (int s = 0; s < DEPTH; s++) begin
            vis = s + 1;
            if (t_rv[p] && pmatch(k, len, t_pat[p], int'(t_ml[p])) && (!bv || int'(t_ml[p]) >= bml)) begin
                bv = 1; bnh = int'(t_nh[p]); bml = int'(t_ml[p]);
            end
            if (t_leaf[p] || int'(t_bit[p]) >= len || int'(t_bit[p]) >= KW || s == DEPTH - 1) break;
            p = k[t_bit[p]] ? int'(t_c1[p]) : int'(t_c0[p]);
        end
        emiss = !bv; enh = bv ? bnh : 0; eml = bv ? bml : 0;
    endfunction

    // issue one key, optionally poke the inputs while busy, and check the outcome
    task automatic lookup(input logic [KW-1:0] k, input int len, input bit poke, input string req);
        int enh, eml, vis, cyc;
        bit emiss;
        ref_walk(k, len, enh, eml, emiss, vis);
        @(negedge clk);
        in_valid = 1'b1; in_key = k; in_len = LW'(len);
        @(posedge clk);
        @(negedge clk);
        check(!in_ready && !res_done, "R2 busy after accept", {in_ready, res_done}, 0);
        if (poke) begin
            in_key = ~k; in_len = LW'(KW);
        end else begin
            in_valid = 1'b0;
        end
        cyc = 0;
        while (cyc < DEPTH + 4) begin
            @(negedge clk);
            in_valid = 1'b0;
            cyc++;
            if (res_done) break;
        end
        check(res_done && cyc == vis, {req, " R9 latency"}, cyc, vis);
        check(res_miss == emiss && int'(res_nh) == enh && int'(res_mlen) == eml, {req, " R8 result"},
              {res_miss, res_nh, res_mlen}, {emiss, NW'(enh), LW'(eml)});
        @(negedge clk);
        check(!res_done && in_ready, "R3 pulse ends", res_done, 0);
        check(!res_miss == !emiss && int'(res_nh) == enh, "R10 result held", res_nh, enh);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [KW-1:0] base, k;
        void'($urandom(32'd7041));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(in_ready && !res_done && !res_miss && res_nh == 0 && res_mlen == 0,
              "R1 reset state", {in_ready, res_done, res_miss, res_nh, res_mlen}, 1 << (2 + NW + LW));

        // R9 / R8: empty self-looping table, full-length key walks to the visit budget and misses
        clear_table();
        lookup(32'hDEAD_BEEF, KW, 1'b0, "R9 budget R8 miss");
        // R7: zero-length key ends at root
        lookup(32'h1234_5678, 0, 1'b0, "R7 zero length");

        // R4: root tests bit 3
        wnode(0, 1'b0, 3, 1, 2, 1'b0, 0, 0, '0);
        wnode(1, 1'b1, 0, 0, 0, 1'b1, 11, 0, '0);
        wnode(2, 1'b1, 0, 0, 0, 1'b1, 22, 0, '0);
        lookup(32'h0000_0000, KW, 1'b0, "R4 zero branch");
        lookup(32'h0000_0008, KW, 1'b0, "R4 one branch");
        // R7: bit 3 not inside a 3-bit key
        lookup(32'h0000_0008, 3, 1'b0, "R7 short key");

        // R6 / R5: root candidate length 4, child leaf shorter, then longer, then failing
        k = 32'h0000_00A5;
        wnode(0, 1'b0, 5, 1, 1, 1'b1, 5, 4, k);
        wnode(1, 1'b1, 0, 0, 0, 1'b1, 9, 2, k);
        lookup(k, KW, 1'b0, "R6 shorter kept out");
        wnode(1, 1'b1, 0, 0, 0, 1'b1, 9, 8, k);
        lookup(k, KW, 1'b0, "R6 longer wins");
        wnode(1, 1'b1, 0, 0, 0, 1'b1, 9, 8, k ^ 32'h1);
        lookup(k, KW, 1'b0, "R5 leaf fail fallback");
        lookup(k, 6, 1'b0, "R5 mask beyond key");
        // R7: bit index past width
        wnode(0, 1'b0, 40, 1, 1, 1'b1, 5, 4, k);
        lookup(k, KW, 1'b0, "R7 index past width");
        // R10: inputs changed during the walk
        wnode(0, 1'b0, 5, 1, 1, 1'b1, 5, 4, k);
        lookup(k, KW, 1'b1, "R10 busy inputs ignored");

        // R11 and randomized trees
        for (int t = 0; t < 30; t++) begin
            base = $urandom;
            for (int a = 0; a < DEPTH; a++) begin
                logic [KW-1:0] pat;
                pat = base;
                if ($urandom % 3 == 0) pat[$urandom % KW] ^= 1'b1;
                wnode(a, ($urandom % 4 == 0) || a >= DEPTH - 4, $urandom % 36,
                      $urandom % DEPTH, $urandom % DEPTH, $urandom % 2,
                      1 + $urandom % 4000, $urandom % (KW + 1), pat);
            end
            for (int q = 0; q < 10; q++) begin
                int len;
                k = base;
                if ($urandom % 2 == 0) k[$urandom % KW] ^= 1'b1;
                len = ($urandom % 3 == 0) ? KW : int'($urandom % (KW + 1));
                lookup(k, len, q == 9, "R11 random tree");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule